// File: doc/BRIEF.md
# Data Access Translation and Fault Checker

This block takes one data access request per cycle and decides its outcome. The outcome is either a physical address with cacheability attributes, or a fault code with a set of memory-management status flags. A request carries a virtual address, an access size in bytes, a read/write flag, a physical-mode flag, a privileged-code flag, an alternate-mode select and a page-table-entry-fetch flag. The current and alternate processor modes are inputs, and so is the result of a translation buffer lookup done outside the block: hit, page number, per-mode read and write enable masks, and the fault-on-read and fault-on-write bits.

The checks run in this order. Alignment comes first. Then the address is resolved by one of three paths: the physical pass-through, the kernel-only direct-mapped superpage window, or the translated path with its permission checks. A resolved address is then tested against the implemented physical width. Addresses in the uncached region are rewritten. The answer is registered and appears one cycle after the request.

Top module: `xlat_data_chk`

## Requirements
- R1: An access whose virtual address ANDed with (size - 1) is nonzero gives fault code 1 (alignment), whatever the other inputs are. Its status is bit 0 (write) set exactly for writes. Size is the byte count (1, 2, 4 or 8).
- R2: rsp_valid is high in the cycle after a cycle with req_valid high, and low after a cycle without a request. All outputs are zero after reset.
- R3: A physical-mode request uses the virtual address unchanged as the physical address.
- R4: A non-physical request with virtual address bits 47:41 equal to 7'h7e is a superpage access. If the current mode (cur_mode, even for privileged code) is not kernel (0), it gives fault code 2 (access violation). Its status is bit 1 (violation) plus bit 0 for writes.
- R5: A superpage access in kernel mode takes the address masked to 44 bits. If bit 40 is set, bits 43:40 are forced to ones; otherwise the address is cut to 40 bits.
- R6: A translated access that misses gives fault code 5 when the page-table-entry-fetch flag is set, and code 4 otherwise. Its status is bit 2 (miss) plus bit 0 for writes.
- R7: A translated hit gives the physical address (page number << 13) + (virtual address bits 12:0).
- R8: The effective mode is cur_mode for ordinary code. For privileged code it is alt_mode when req_alt is set, and kernel otherwise. The enable bit checked is the one at index (effective mode). Modes: kernel 0, executive 1, supervisor 2, user 3.
- R9: On a write, a clear write-enable bit gives fault code 3 (page fault) with status bits 0 and 1, plus bit 4 (fault-on-write) when that entry bit is set. Otherwise a set fault-on-write bit gives code 3 with status bits 0 and 4.
- R10: On a read, a clear read-enable bit gives fault code 2 with status bit 1, plus bit 3 (fault-on-read) when that entry bit is set. Otherwise a set fault-on-read bit gives code 3 with status bit 3 only.
- R11: A resolved physical address with any bit above bit 43 set gives fault code 6 (machine check) with zero status.
- R12: A resolved address with bit 43 set and bits 43:32 all ones gives fault code 7 (unimplemented control space). With bit 43 set and bits 43:32 not all ones, the access is marked uncached and strictly ordered, and bits 42:35 are cleared. Other faultless accesses are cached, with fault code 0 and zero status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 64 | Virtual address |
| req_size | input | 4 | Access size in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phys | input | 1 | Physical-mode request |
| req_priv | input | 1 | Request from privileged code |
| req_alt | input | 1 | Use alternate mode for privileged code |
| req_pte | input | 1 | Request is a page-table-entry fetch |
| cur_mode | input | 2 | Current processor mode |
| alt_mode | input | 2 | Alternate processor mode |
| tlb_hit | input | 1 | Lookup hit |
| tlb_ppn | input | 51 | Physical page number from lookup |
| tlb_rd_en | input | 4 | Per-mode read enables |
| tlb_wr_en | input | 4 | Per-mode write enables |
| tlb_fonr | input | 1 | Fault-on-read bit |
| tlb_fonw | input | 1 | Fault-on-write bit |
| rsp_valid | output | 1 | Result valid |
| rsp_fault | output | 3 | Fault code (0 = none) |
| rsp_stat | output | 5 | Status flags {fonw, fonr, miss, acv, wr} |
| rsp_paddr | output | 64 | Physical address |
| rsp_uncached | output | 1 | Access is uncached |
| rsp_strict | output | 1 | Access is strictly ordered |

## Verification
The assertions check some behaviour on every cycle. They check the one-cycle response timing and that a misaligned request always ends as an alignment fault. They also check that a non-kernel superpage access is always a violation, that a miss always carries the miss flag, that an over-wide physical request always ends in a machine check, and that an uncached response always has bits 42:35 cleared and strict ordering set. Only the bench scenarios can show the rest. These are the exact fault ranking between enable failures and the fault-on bits, the effective-mode selection for privileged code, the superpage sign extension, and the exact translated addresses. The bench sweeps every enable mask, fault-on combination and mode source against an arithmetic model.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int NUM_MODES   = 4;
    localparam int MODE_W      = 2;
    localparam int SP_TAG_HI   = 47;
    localparam int SP_TAG_LO   = 41;
    localparam logic [SP_TAG_HI-SP_TAG_LO:0] SP_TAG_VAL = 7'h7e;
    localparam int SP_EXT_BIT  = 40;
    localparam int UNC_BIT     = 43;
    localparam int UNC_CLR_HI  = 42;
    localparam int UNC_CLR_LO  = 35;
    localparam int CTL_LO      = 32;

    typedef enum logic [MODE_W-1:0] {
        MODE_KERN = 2'd0,
        MODE_EXEC = 2'd1,
        MODE_SUPV = 2'd2,
        MODE_USER = 2'd3
    } cpu_mode_e;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_ALIGN    = 3'd1,
        FLT_ACV      = 3'd2,
        FLT_PAGE     = 3'd3,
        FLT_MISS     = 3'd4,
        FLT_MISS_PTE = 3'd5,
        FLT_MCHK     = 3'd6,
        FLT_UNIMPL   = 3'd7
    } xlat_fault_e;

    typedef struct packed {
        logic fonw;
        logic fonr;
        logic miss;
        logic acv;
        logic wr;
    } xlat_stat_t;

    localparam xlat_stat_t STAT_ZERO = '{default: 1'b0};

    function automatic cpu_mode_e pick_mode(input logic priv, input logic alt,
                                            input cpu_mode_e cur, input cpu_mode_e altm);
        if (!priv)
            return cur;
        return alt ? altm : MODE_KERN;
    endfunction

endpackage

// File: rtl/xlat_align_chk.sv
module xlat_align_chk
    import xlat_pkg::*;
#(
    parameter int SIZE_W = 4
) (
    input  logic [SIZE_W-1:0] addr_lo_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              write_i,
    output logic              misaligned_o,
    output xlat_stat_t        stat_o
);
    logic [SIZE_W-1:0] size_mask;

    always_comb begin
        size_mask    = size_i - SIZE_W'(1);
        misaligned_o = |(addr_lo_i & size_mask);
        stat_o       = STAT_ZERO;
        stat_o.wr    = write_i;
    end
endmodule

// File: rtl/xlat_perm_chk.sv
module xlat_perm_chk
    import xlat_pkg::*;
(
    input  logic                 write_i,
    input  cpu_mode_e            mode_i,
    input  logic [NUM_MODES-1:0] rd_en_i,
    input  logic [NUM_MODES-1:0] wr_en_i,
    input  logic                 fonr_i,
    input  logic                 fonw_i,
    output xlat_fault_e          fault_o,
    output xlat_stat_t           stat_o
);
    logic rd_ok;
    logic wr_ok;

    always_comb begin
        rd_ok   = rd_en_i[mode_i];
        wr_ok   = wr_en_i[mode_i];
        fault_o = FLT_NONE;
        stat_o  = STAT_ZERO;
        if (write_i) begin
            if (!wr_ok) begin
                fault_o     = FLT_PAGE;
                stat_o.wr   = 1'b1;
                stat_o.acv  = 1'b1;
                stat_o.fonw = fonw_i;
            end else if (fonw_i) begin
                fault_o     = FLT_PAGE;
                stat_o.wr   = 1'b1;
                stat_o.fonw = 1'b1;
            end
        end else begin
            if (!rd_ok) begin
                fault_o     = FLT_ACV;
                stat_o.acv  = 1'b1;
                stat_o.fonr = fonr_i;
            end else if (fonr_i) begin
                fault_o     = FLT_PAGE;
                stat_o.fonr = 1'b1;
            end
        end
    end
endmodule

// File: rtl/xlat_pa_post.sv
module xlat_pa_post
    import xlat_pkg::*;
#(
    parameter int PA_W      = 64,
    parameter int PA_IMPL_W = 44
) (
    input  logic [PA_W-1:0] pa_i,
    output logic [PA_W-1:0] pa_o,
    output logic            mchk_o,
    output logic            unimpl_o,
    output logic            uncached_o
);
    localparam int CTL_W = UNC_BIT - CTL_LO + 1;
    localparam int CLR_W = UNC_CLR_HI - UNC_CLR_LO + 1;
    localparam logic [PA_W-1:0] CLR_MASK = ~({{(PA_W-CLR_W){1'b0}}, {CLR_W{1'b1}}} << UNC_CLR_LO);

    logic in_ctl;

    always_comb begin
        mchk_o     = |(pa_i >> PA_IMPL_W);
        in_ctl     = (pa_i[UNC_BIT:CTL_LO] == {CTL_W{1'b1}});
        unimpl_o   = 1'b0;
        uncached_o = 1'b0;
        pa_o       = pa_i;
        if (!mchk_o && pa_i[UNC_BIT]) begin
            if (in_ctl) begin
                unimpl_o = 1'b1;
            end else begin
                uncached_o = 1'b1;
                pa_o       = pa_i & CLR_MASK;
            end
        end
    end
endmodule

// File: rtl/xlat_data_chk.sv
module xlat_data_chk
    import xlat_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int SIZE_W    = 4,
    parameter int PG_SHIFT  = 13,
    parameter int PA_IMPL_W = 44,
    parameter int PPN_W     = VA_W - PG_SHIFT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [VA_W-1:0]      req_vaddr,
    input  logic [SIZE_W-1:0]    req_size,
    input  logic                 req_write,
    input  logic                 req_phys,
    input  logic                 req_priv,
    input  logic                 req_alt,
    input  logic                 req_pte,
    input  logic [MODE_W-1:0]    cur_mode,
    input  logic [MODE_W-1:0]    alt_mode,
    input  logic                 tlb_hit,
    input  logic [PPN_W-1:0]     tlb_ppn,
    input  logic [NUM_MODES-1:0] tlb_rd_en,
    input  logic [NUM_MODES-1:0] tlb_wr_en,
    input  logic                 tlb_fonr,
    input  logic                 tlb_fonw,
    output logic                 rsp_valid,
    output logic [2:0]           rsp_fault,
    output logic [4:0]           rsp_stat,
    output logic [VA_W-1:0]      rsp_paddr,
    output logic                 rsp_uncached,
    output logic                 rsp_strict
);
    localparam logic [VA_W-1:0] IMPL_MASK = {{(VA_W-PA_IMPL_W){1'b0}}, {PA_IMPL_W{1'b1}}};
    localparam logic [VA_W-1:0] EXT_ONES  = {{(VA_W-4){1'b0}}, 4'hF} << SP_EXT_BIT;
    localparam logic [VA_W-1:0] LOW_MASK  = (VA_W'(1) << SP_EXT_BIT) - VA_W'(1);

    cpu_mode_e   eff_mode;
    logic        misaligned;
    xlat_stat_t  align_stat;
    xlat_fault_e perm_fault;
    xlat_stat_t  perm_stat;
    logic        in_sp;
    logic [VA_W-1:0] sp_masked;
    logic [VA_W-1:0] sp_pa;
    logic [VA_W-1:0] hit_pa;
    logic [VA_W-1:0] pre_pa;
    logic [VA_W-1:0] post_pa;
    logic        post_mchk;
    logic        post_unimpl;
    logic        post_unc;

    xlat_fault_e nxt_fault;
    xlat_stat_t  nxt_stat;
    logic [VA_W-1:0] nxt_pa;
    logic        nxt_unc;

    xlat_fault_e fault_q;
    xlat_stat_t  stat_q;

    xlat_align_chk #(.SIZE_W(SIZE_W)) u_align (
        .addr_lo_i    (req_vaddr[SIZE_W-1:0]),
        .size_i       (req_size),
        .write_i      (req_write),
        .misaligned_o (misaligned),
        .stat_o       (align_stat)
    );

    assign eff_mode = pick_mode(req_priv, req_alt, cpu_mode_e'(cur_mode), cpu_mode_e'(alt_mode));

    xlat_perm_chk u_perm (
        .write_i (req_write),
        .mode_i  (eff_mode),
        .rd_en_i (tlb_rd_en),
        .wr_en_i (tlb_wr_en),
        .fonr_i  (tlb_fonr),
        .fonw_i  (tlb_fonw),
        .fault_o (perm_fault),
        .stat_o  (perm_stat)
    );

    always_comb begin
        in_sp     = (req_vaddr[SP_TAG_HI:SP_TAG_LO] == SP_TAG_VAL);
        sp_masked = req_vaddr & IMPL_MASK;
        sp_pa     = sp_masked[SP_EXT_BIT] ? (sp_masked | EXT_ONES) : (sp_masked & LOW_MASK);
        hit_pa    = {tlb_ppn, req_vaddr[PG_SHIFT-1:0]};
    end

    xlat_pa_post #(.PA_W(VA_W), .PA_IMPL_W(PA_IMPL_W)) u_post (
        .pa_i       (pre_pa),
        .pa_o       (post_pa),
        .mchk_o     (post_mchk),
        .unimpl_o   (post_unimpl),
        .uncached_o (post_unc)
    );

    always_comb begin
        nxt_fault = FLT_NONE;
        nxt_stat  = STAT_ZERO;
        pre_pa    = req_vaddr;
        if (misaligned) begin
            nxt_fault = FLT_ALIGN;
            nxt_stat  = align_stat;
        end else if (req_phys) begin
            pre_pa = req_vaddr;
        end else if (in_sp) begin
            pre_pa = sp_pa;
            if (cpu_mode_e'(cur_mode) != MODE_KERN) begin
                nxt_fault    = FLT_ACV;
                nxt_stat.acv = 1'b1;
                nxt_stat.wr  = req_write;
            end
        end else if (!tlb_hit) begin
            nxt_fault     = req_pte ? FLT_MISS_PTE : FLT_MISS;
            nxt_stat.miss = 1'b1;
            nxt_stat.wr   = req_write;
        end else begin
            pre_pa    = hit_pa;
            nxt_fault = perm_fault;
            nxt_stat  = perm_stat;
        end

        nxt_pa  = post_pa;
        nxt_unc = 1'b0;
        if (nxt_fault == FLT_NONE) begin
            if (post_mchk)
                nxt_fault = FLT_MCHK;
            else if (post_unimpl)
                nxt_fault = FLT_UNIMPL;
            else
                nxt_unc = post_unc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            fault_q      <= FLT_NONE;
            stat_q       <= STAT_ZERO;
            rsp_paddr    <= '0;
            rsp_uncached <= 1'b0;
            rsp_strict   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                fault_q      <= nxt_fault;
                stat_q       <= nxt_stat;
                rsp_paddr    <= nxt_pa;
                rsp_uncached <= nxt_unc;
                rsp_strict   <= nxt_unc;
            end
        end
    end

    assign rsp_fault = fault_q;
    assign rsp_stat  = stat_q;

    // Assertions

    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_rsp_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    p_align_wins_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ((req_vaddr[SIZE_W-1:0] & (req_size - SIZE_W'(1))) != '0))
        |=> (rsp_fault == 3'd1));

    p_sp_nonkernel_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ((req_vaddr[SIZE_W-1:0] & (req_size - SIZE_W'(1))) == '0) && !req_phys
         && req_vaddr[SP_TAG_HI:SP_TAG_LO] == SP_TAG_VAL && cur_mode != 2'd0)
        |=> (rsp_fault == 3'd2 && rsp_stat[1]));

    p_miss_flag_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ((req_vaddr[SIZE_W-1:0] & (req_size - SIZE_W'(1))) == '0) && !req_phys
         && req_vaddr[SP_TAG_HI:SP_TAG_LO] != SP_TAG_VAL && !tlb_hit)
        |=> ((rsp_fault == 3'd4 || rsp_fault == 3'd5) && rsp_stat[2]));

    p_phys_wide_mchk_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ((req_vaddr[SIZE_W-1:0] & (req_size - SIZE_W'(1))) == '0) && req_phys
         && (req_vaddr >> PA_IMPL_W) != '0)
        |=> (rsp_fault == 3'd6 && rsp_stat == 5'd0));

    p_uncached_shape_r12: assert property (@(posedge clk) disable iff (rst)
        rsp_uncached |-> (rsp_strict && rsp_fault == 3'd0
                          && rsp_paddr[UNC_CLR_HI:UNC_CLR_LO] == '0 && rsp_paddr[UNC_BIT]));

endmodule

// File: tb/xlat_data_chk_tb_top.sv
`timescale 1ns/1ps
module xlat_data_chk_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        d_valid = 1'b0;
    logic [63:0] d_va = '0;
    logic [3:0]  d_size = 4'd1;
    logic        d_wr = 1'b0;
    logic        d_phys = 1'b0;
    logic        d_priv = 1'b0;
    logic        d_alt = 1'b0;
    logic        d_pte = 1'b0;
    logic [1:0]  d_cur = 2'd0;
    logic [1:0]  d_altm = 2'd0;
    logic        d_hit = 1'b0;
    logic [50:0] d_ppn = '0;
    logic [3:0]  d_ren = '0;
    logic [3:0]  d_wen = '0;
    logic        d_fonr = 1'b0;
    logic        d_fonw = 1'b0;

    logic        o_valid;
    logic [2:0]  o_fault;
    logic [4:0]  o_stat;
    logic [63:0] o_pa;
    logic        o_unc;
    logic        o_strict;

    int n_tests = 0;
    int n_fail  = 0;

    logic [2:0]  e_f;
    logic [4:0]  e_st;
    logic [63:0] e_pa;
    logic        e_unc;

    always #4 clk = ~clk;

    xlat_data_chk dut_i (
        .clk(clk), .rst(rst), .req_valid(d_valid), .req_vaddr(d_va), .req_size(d_size),
        .req_write(d_wr), .req_phys(d_phys), .req_priv(d_priv), .req_alt(d_alt),
        .req_pte(d_pte), .cur_mode(d_cur), .alt_mode(d_altm), .tlb_hit(d_hit),
        .tlb_ppn(d_ppn), .tlb_rd_en(d_ren), .tlb_wr_en(d_wen), .tlb_fonr(d_fonr),
        .tlb_fonw(d_fonw), .rsp_valid(o_valid), .rsp_fault(o_fault), .rsp_stat(o_stat),
        .rsp_paddr(o_pa), .rsp_uncached(o_unc), .rsp_strict(o_strict)
    );

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        summary();
        $finish;
    end

    // Reference model written from the requirements
    task automatic model();
        logic [1:0]  em;
        logic [63:0] p;
        logic        mis;
        e_f = 3'd0; e_st = 5'd0; e_unc = 1'b0; p = 64'd0;
        mis = ((d_va[3:0] & (d_size - 4'd1)) != 4'd0);
        em  = d_priv ? (d_alt ? d_altm : 2'd0) : d_cur;
        if (mis) begin
            e_f = 3'd1; e_st = d_wr ? 5'd1 : 5'd0;
        end else if (d_phys) begin
            p = d_va;
        end else if (d_va[47:41] == 7'h7e) begin
            if (d_cur != 2'd0) begin
                e_f = 3'd2; e_st = 5'd2 | (d_wr ? 5'd1 : 5'd0);
            end else begin
                p = d_va & 64'h0000_0FFF_FFFF_FFFF;
                if (p[40]) p = p | 64'h0000_0F00_0000_0000;
                else       p = p & 64'h0000_00FF_FFFF_FFFF;
            end
        end else if (!d_hit) begin
            e_f = d_pte ? 3'd5 : 3'd4;
            e_st = 5'd4 | (d_wr ? 5'd1 : 5'd0);
        end else begin
            p = {13'd0, d_ppn} * 64'd8192 + (d_va & 64'h1FFF);
            if (d_wr) begin
                if (!d_wen[em]) begin e_f = 3'd3; e_st = 5'd3 | (d_fonw ? 5'd16 : 5'd0); end
                else if (d_fonw) begin e_f = 3'd3; e_st = 5'd17; end
            end else begin
                if (!d_ren[em]) begin e_f = 3'd2; e_st = 5'd2 | (d_fonr ? 5'd8 : 5'd0); end
                else if (d_fonr) begin e_f = 3'd3; e_st = 5'd8; end
            end
        end
        if (e_f == 3'd0) begin
            if (p >= 64'h0000_1000_0000_0000) e_f = 3'd6;
            else if (p[43]) begin
                if (p[43:32] == 12'hFFF) e_f = 3'd7;
                else begin e_unc = 1'b1; p = p & ~(64'hFF << 35); end
            end
        end
        e_pa = p;
    endtask

    // Called at a negedge: drive request, wait one cycle, compare at next negedge
    task automatic run(input string req);
        model();
        d_valid = 1'b1;
        @(negedge clk);
        n_tests++;
        if (o_valid !== 1'b1 || o_fault !== e_f || o_stat !== e_st ||
            (e_f == 3'd0 && (o_pa !== e_pa || o_unc !== e_unc || o_strict !== e_unc))) begin
            n_fail++;
            $display("FAIL %s: actual v=%b f=%0d st=%b pa=%h unc=%b str=%b expected f=%0d st=%b pa=%h unc=%b (va=%h)",
                     req, o_valid, o_fault, o_stat, o_pa, o_unc, o_strict, e_f, e_st, e_pa, e_unc, d_va);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state
        n_tests++;
        if (o_valid !== 1'b0 || o_fault !== 3'd0 || o_stat !== 5'd0 || o_pa !== 64'd0 || o_unc !== 1'b0) begin
            n_fail++;
            $display("FAIL R2 reset: actual v=%b f=%0d st=%b pa=%h expected all zero", o_valid, o_fault, o_stat, o_pa);
        end
        rst = 1'b0;
        @(negedge clk);

        // R1 / R3: alignment sweep over physical-mode requests
        d_phys = 1'b1;
        for (int s = 0; s < 4; s++)
            for (int off = 0; off < 8; off++)
                for (int w = 0; w < 2; w++) begin
                    d_size = 4'd1 << s;
                    d_va   = 64'h0000_0000_0000_1000 + 64'(off);
                    d_wr   = w[0];
                    run("R1/R3 align");
                end

        // R1 wins over superpage violation and a miss
        d_phys = 1'b0; d_cur = 2'd3; d_size = 4'd8; d_va = 64'h0000_FC00_0000_0004;
        run("R1 over superpage");
        d_va = 64'h0000_0000_0000_2002; d_hit = 1'b0; d_size = 4'd4;
        run("R1 over miss");

        // R2: idle cycle gives no response
        d_valid = 1'b0;
        @(negedge clk);
        n_tests++;
        if (o_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R2 idle: actual v=%b expected 0", o_valid);
        end

        // R8 / R9 / R10 / R7: permission sweep across all mode sources
        d_size = 4'd8; d_hit = 1'b1; d_ppn = 51'h1234;
        d_va = 64'h0000_0012_3456_A008;
        for (int mc = 0; mc < 9; mc++)
            for (int en = 0; en < 16; en++)
                for (int fo = 0; fo < 4; fo++)
                    for (int w = 0; w < 2; w++) begin
                        if (mc < 4) begin d_priv = 1'b0; d_cur = 2'(mc); d_alt = 1'b0; d_altm = 2'(3 - mc); end
                        else if (mc == 4) begin d_priv = 1'b1; d_alt = 1'b0; d_cur = 2'd3; d_altm = 2'd3; end
                        else begin d_priv = 1'b1; d_alt = 1'b1; d_altm = 2'(mc - 5); d_cur = 2'(8 - mc); end
                        d_ren = 4'(en); d_wen = 4'(~en); d_fonr = fo[0]; d_fonw = fo[1]; d_wr = w[0];
                        run("R8/R9/R10 perm");
                    end

        // R7 / R11 / R12: translated addresses
        d_priv = 1'b0; d_cur = 2'd0; d_ren = 4'hF; d_wen = 4'hF; d_fonr = 1'b0; d_fonw = 1'b0;
        for (int k = 0; k < 6; k++) begin
            d_ppn = (k == 0) ? 51'h7 : (k == 1) ? (51'd1 << 30) | 51'h5555 :
                    (k == 2) ? (51'd1 << 31) : (k == 3) ? 51'h7FFF_FFFF : (k == 4) ? 51'h2_0000 : 51'h1;
            d_va = 64'h0000_0000_0000_1FF8 | (64'(k) << 3);
            d_wr = k[0];
            run("R7/R11/R12 hit address");
        end

        // R4 / R5: superpage window, current mode decides even for privileged code
        for (int m = 0; m < 4; m++)
            for (int w = 0; w < 2; w++)
                for (int b = 0; b < 2; b++)
                    for (int pv = 0; pv < 2; pv++) begin
                        d_cur = 2'(m); d_wr = w[0]; d_priv = pv[0]; d_alt = 1'b1; d_altm = 2'd0;
                        d_hit = 1'b0;
                        d_va = 64'h0000_FC00_1234_5678 | (b[0] ? 64'h0000_0100_0000_0000 : 64'd0);
                        run("R4/R5 superpage");
                    end
        d_cur = 2'd0; d_va = 64'h0000_FDFF_FFF0_0000; d_priv = 1'b0;
        run("R5/R12 superpage into control space");

        // R6: misses
        d_va = 64'h0000_0000_0040_0000; d_hit = 1'b0;
        for (int pt = 0; pt < 2; pt++)
            for (int w = 0; w < 2; w++) begin
                d_pte = pt[0]; d_wr = w[0]; d_cur = 2'(pt + w);
                run("R6 miss");
            end
        d_pte = 1'b0;

        // R3 / R11 / R12: physical-mode boundary addresses
        d_phys = 1'b1;
        d_va = 64'h0000_1000_0000_0000; run("R11 bit44");
        d_va = 64'h8000_0000_0000_0000; run("R11 top bit");
        d_va = 64'h0000_0FFF_FFF0_0000; run("R12 control space");
        d_va = 64'h0000_0FFF_0000_0000; run("R12 control space base");
        d_va = 64'h0000_0FFE_FFFF_FFF8; run("R12 just below control space");
        d_va = 64'h0000_087F_8000_1000; run("R12 uncached clear");
        d_va = 64'h0000_07FF_FFFF_FFF8; run("R3/R12 cached top");
        d_va = 64'h0000_0000_0000_0000; run("R3 zero");

        d_valid = 1'b0;
        @(negedge clk);
        summary();
        $finish;
    end

endmodule